// File: doc/BRIEF.md
# Full-Duplex Clocked Serial Port with Handshake Flags

This block is a clocked serial port for a host processor. It shifts one byte out on a data-out pin and shifts one byte in on a data-in pin during the same frame. Both directions use a serial clock that the block itself produces by dividing the system clock. The host reaches the block through a small register bus with five locations: transmit data, receive data, status, control and bit rate. Three status flags govern the data flow: transmit-empty, receive-full and overrun. Each flag is cleared by a read-then-write handshake. The rising edges of the first two flags are also reported as one-cycle interrupt pulses.

A transfer engine can serve the port in place of the host. It uses the same bus and marks its cycles with a qualifier input. An engine write to the transmit data location clears transmit-empty on its own, and an engine read of the receive data location clears receive-full. Both auto-clears are suppressed when the engine signals that they are disabled or that its transfer count has run out. A receive overrun stops all serial traffic until the host clears it.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, the control register (address 3) reads 0, the status register (address 2) reads 0x01, the serial clock and data-out are high, and both interrupt outputs are low.
- R2: Control bit 0 enables the transmitter and bit 1 the receiver. A control write takes effect only when the enables were both 0 before, or the written pair is 00, or it equals the current pair. Any other control write, such as 01 to 11 or 01 to 10, is ignored.
- R3: Status bit 0 is transmit-empty, bit 1 is receive-full and bit 2 is overrun. A host write of 0 to a flag clears it only if the host has read that flag as 1 since it last became 1. Writing 1 to a flag leaves it unchanged.
- R4: A frame starts when no frame is running, overrun is 0, and either the transmitter is enabled with transmit-empty 0, or only the receiver is enabled. At the start, the transmit data byte (address 0) moves into the shifter and transmit-empty returns to 1. The byte leaves on data-out least significant bit first, with 8 bits per frame.
- R5: When a frame ends with the receiver enabled and receive-full 0, the received byte is loaded into the receive data register (address 1) and receive-full becomes 1.
- R6: When a frame ends with the receiver enabled and receive-full still 1, overrun becomes 1 and the receive data register keeps its old value. No frame starts while overrun is 1, and traffic resumes once it is cleared.
- R7: The serial clock idles high. Within a frame, each low half and each high half lasts N+1 system clocks, where N is the bit-rate register (address 4). Data-out changes on falling edges and data-in is sampled on rising edges.
- R8: The transmit interrupt output is high for exactly one cycle on each 0-to-1 change of transmit-empty. The receive interrupt output does the same for receive-full.
- R9: An engine write to address 0 clears transmit-empty, and an engine read of address 1 clears receive-full, only while the engine's auto-clear-disable input is 0 and its count-zero input is 0.
- R10: A control write that turns the transmitter off sets transmit-empty to 1 and holds data-out high. Turning the receiver off leaves receive-full and overrun unchanged.
- R11: If transmit-empty has been cleared before a frame ends, the next frame follows without an idle half period. A byte whose receive-full was cleared before the end of the next frame is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register location |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing on status reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| eng_acc | input | 1 | Current bus cycle belongs to the transfer engine |
| eng_no_autoclr | input | 1 | Engine requests no automatic flag clear |
| eng_count_zero | input | 1 | Engine transfer count has reached zero |
| ser_clk | output | 1 | Serial clock |
| ser_dout | output | 1 | Serial data out |
| ser_din | input | 1 | Serial data in |
| irq_tx_empty | output | 1 | Transmit-empty rising pulse |
| irq_rx_full | output | 1 | Receive-full rising pulse |

## Verification
The assertions assume a single bus master per cycle, with read and write strobes never raised together. They also assume engine cycles touch only the two data locations. The bench drives every bus access from one task at the falling clock edge with the other strobe low. It uses the engine qualifier only for data-location accesses. Data-in is looped back from data-out, so every received byte can be predicted from the byte sent.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
    typedef enum logic [2:0] {
        REG_TXD  = 3'd0,
        REG_RXD  = 3'd1,
        REG_STAT = 3'd2,
        REG_CTRL = 3'd3,
        REG_RATE = 3'd4
    } ssp_reg_e;

    localparam int ST_TXE = 0;
    localparam int ST_RXF = 1;
    localparam int ST_OVR = 2;
    localparam int CT_TX  = 0;
    localparam int CT_RX  = 1;
endpackage

// File: rtl/ssp_baud.sv
`timescale 1ns/1ps
module ssp_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        // half period ends when the count reaches N (>= tolerates N shrinking mid-frame)
        tick  = run && (cnt_q >= div_n);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              sdi,
    output logic              busy,
    output logic              sclk,
    output logic              sdo,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              done;
        logic [BIT_W-1:0]  idx;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.sclk = 1'b1;
        end else if (start && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.sclk = 1'b0;
            s_d.idx  = '0;
            s_d.tx   = tx_byte;
            s_d.rx   = '0;
        end else if (s_q.busy && tick) begin
            s_d.sclk = !s_q.sclk;
            if (!s_q.sclk) begin
                // rising edge: sample the input pin
                s_d.rx = {sdi, s_q.rx[DATA_W-1:1]};
                if (s_q.idx == LAST_BIT) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end else begin
                // falling edge: present the next bit
                s_d.tx = {1'b1, s_q.tx[DATA_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sclk <= 1'b1;
            s_q.tx   <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = s_q.busy;
    assign sclk    = s_q.sclk;
    assign sdo     = s_q.tx[0];
    assign done    = s_q.done;
    assign rx_byte = s_q.rx;
endmodule

// File: rtl/ssp_ctrl.sv
`timescale 1ns/1ps
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_acc,
    input  logic              eng_no_autoclr,
    input  logic              eng_count_zero,
    input  logic              busy,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              start,
    output logic              abort,
    output logic [DATA_W-1:0] tx_byte,
    output logic [DIV_W-1:0]  div_n,
    output logic              tx_en,
    output logic              rx_en,
    output logic              txe,
    output logic              rxf,
    output logic              ovr,
    output logic              tx_act,
    output logic              irq_tx,
    output logic              irq_rx
);
    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] txd;
        logic [DATA_W-1:0] rxd;
        logic              txe;
        logic              rxf;
        logic              ovr;
        logic              arm_txe;
        logic              arm_rxf;
        logic              arm_ovr;
        logic              tx_act;
        logic              rx_act;
        logic              irq_tx;
        logic              irq_rx;
    } ctl_t;

    ctl_t r_d, r_q;

    logic       auto_ok, host_st_rd, st_wr, ctl_wr, ovr_set, accept;
    logic [1:0] en_old, en_new;

    always_comb begin
        r_d        = r_q;
        r_d.irq_tx = 1'b0;
        r_d.irq_rx = 1'b0;

        auto_ok    = !eng_no_autoclr && !eng_count_zero;
        host_st_rd = bus_rd && !eng_acc && (bus_addr == REG_STAT);
        st_wr      = bus_wr && !eng_acc && (bus_addr == REG_STAT);
        ctl_wr     = bus_wr && !eng_acc && (bus_addr == REG_CTRL);
        ovr_set    = done && r_q.rx_act && r_q.rxf;

        start = !busy && !r_q.ovr && !ovr_set &&
                ((r_q.tx_en && !r_q.txe) || (!r_q.tx_en && r_q.rx_en));

        // data and rate locations
        if (bus_wr && (bus_addr == REG_TXD)) begin
            r_d.txd = bus_wdata;
            if (eng_acc && auto_ok) r_d.txe = 1'b0;
        end
        if (bus_wr && !eng_acc && (bus_addr == REG_RATE))
            r_d.div = bus_wdata[DIV_W-1:0];
        if (bus_rd && eng_acc && (bus_addr == REG_RXD) && auto_ok)
            r_d.rxf = 1'b0;

        // read-1-then-write-0 clearing
        if (st_wr) begin
            if (!bus_wdata[ST_TXE] && r_q.arm_txe) r_d.txe = 1'b0;
            if (!bus_wdata[ST_RXF] && r_q.arm_rxf) r_d.rxf = 1'b0;
            if (!bus_wdata[ST_OVR] && r_q.arm_ovr) r_d.ovr = 1'b0;
        end

        // frame completion
        if (done && r_q.rx_act) begin
            if (r_q.rxf) begin
                r_d.ovr = 1'b1;
            end else begin
                r_d.rxd = rx_byte;
                r_d.rxf = 1'b1;
            end
        end

        // frame start
        if (start) begin
            r_d.tx_act = r_q.tx_en;
            r_d.rx_act = r_q.rx_en;
            if (r_q.tx_en) r_d.txe = 1'b1;
        end

        // enable pair: change only from 00, to 00, or to the same pair
        en_old = {r_q.rx_en, r_q.tx_en};
        en_new = bus_wdata[1:0];
        accept = (en_old == 2'b00) || (en_new == 2'b00) || (en_new == en_old);
        if (ctl_wr && accept) begin
            r_d.tx_en = en_new[CT_TX];
            r_d.rx_en = en_new[CT_RX];
            if (!en_new[CT_TX]) r_d.txe = 1'b1;
        end

        r_d.arm_txe = r_d.txe && (r_q.arm_txe || (host_st_rd && r_q.txe));
        r_d.arm_rxf = r_d.rxf && (r_q.arm_rxf || (host_st_rd && r_q.rxf));
        r_d.arm_ovr = r_d.ovr && (r_q.arm_ovr || (host_st_rd && r_q.ovr));

        r_d.irq_tx = r_d.txe && !r_q.txe;
        r_d.irq_rx = r_d.rxf && !r_q.rxf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.txe <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_TXD:  bus_rdata = r_q.txd;
            REG_RXD:  bus_rdata = r_q.rxd;
            REG_STAT: begin
                bus_rdata[ST_TXE] = r_q.txe;
                bus_rdata[ST_RXF] = r_q.rxf;
                bus_rdata[ST_OVR] = r_q.ovr;
            end
            REG_CTRL: begin
                bus_rdata[CT_TX] = r_q.tx_en;
                bus_rdata[CT_RX] = r_q.rx_en;
            end
            REG_RATE: bus_rdata[DIV_W-1:0] = r_q.div;
            default:  bus_rdata = '0;
        endcase
    end

    assign abort   = !(r_q.tx_en || r_q.rx_en);
    assign tx_byte = r_q.txd;
    assign div_n   = r_q.div;
    assign tx_en   = r_q.tx_en;
    assign rx_en   = r_q.rx_en;
    assign txe     = r_q.txe;
    assign rxf     = r_q.rxf;
    assign ovr     = r_q.ovr;
    assign tx_act  = r_q.tx_act;
    assign irq_tx  = r_q.irq_tx;
    assign irq_rx  = r_q.irq_rx;
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_acc,
    input  logic              eng_no_autoclr,
    input  logic              eng_count_zero,
    output logic              ser_clk,
    output logic              ser_dout,
    input  logic              ser_din,
    output logic              irq_tx_empty,
    output logic              irq_rx_full
);
    logic              sh_busy, sh_done, sh_sdo, sh_start, sh_abort, baud_tick;
    logic [DATA_W-1:0] sh_rx, sh_tx;
    logic [DIV_W-1:0]  div_n;
    logic              tx_en, rx_en, txe, rxf, ovr, tx_act;

    ssp_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .eng_acc        (eng_acc),
        .eng_no_autoclr (eng_no_autoclr),
        .eng_count_zero (eng_count_zero),
        .busy           (sh_busy),
        .done           (sh_done),
        .rx_byte        (sh_rx),
        .start          (sh_start),
        .abort          (sh_abort),
        .tx_byte        (sh_tx),
        .div_n          (div_n),
        .tx_en          (tx_en),
        .rx_en          (rx_en),
        .txe            (txe),
        .rxf            (rxf),
        .ovr            (ovr),
        .tx_act         (tx_act),
        .irq_tx         (irq_tx_empty),
        .irq_rx         (irq_rx_full)
    );

    ssp_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (sh_busy),
        .div_n (div_n),
        .tick  (baud_tick)
    );

    ssp_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .abort   (sh_abort),
        .tick    (baud_tick),
        .tx_byte (sh_tx),
        .sdi     (ser_din),
        .busy    (sh_busy),
        .sclk    (ser_clk),
        .sdo     (sh_sdo),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    assign ser_dout = (sh_busy && tx_act && tx_en) ? sh_sdo : 1'b1;
endmodule

// File: rtl/ssp_chk.sv
`timescale 1ns/1ps
module ssp_chk
    import ssp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sclk,
    input logic       txe,
    input logic       rxf,
    input logic       ovr,
    input logic       tx_en,
    input logic       rx_en,
    input logic       tx_act,
    input logic       irq_tx,
    input logic       irq_rx,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [1:0] wdata_lo
);
    // R7
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk);

    // R6
    overrun_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !busy) |=> !busy);

    // R4
    load_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && tx_act) |-> txe);

    // R8
    tx_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (txe && !$past(txe)));

    // R8
    rx_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (rxf && !$past(rxf)));

    // R2
    enable_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_en ^ rx_en) && bus_wr && (bus_addr == REG_CTRL) && (wdata_lo == 2'b11))
        |=> (tx_en == $past(tx_en)) && (rx_en == $past(rx_en)));

    // R3
    write_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf && bus_wr && (bus_addr == REG_STAT) && wdata_lo[ST_RXF]) |=> rxf);

    // R10
    tx_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> txe);
endmodule

bind sync_serial_port ssp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (sh_busy),
    .sclk     (ser_clk),
    .txe      (txe),
    .rxf      (rxf),
    .ovr      (ovr),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .tx_act   (tx_act),
    .irq_tx   (irq_tx_empty),
    .irq_rx   (irq_rx_full),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[1:0])
);

// File: tb/sync_serial_port_test.sv
`timescale 1ns/1ps
module sync_serial_port_test;
    localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_STAT = 3'd2,
                           A_CTRL = 3'd3, A_RATE = 3'd4;
    localparam int NVEC = 6;
    // {bit-rate N, data byte}
    localparam logic [15:0] VEC [NVEC] = '{16'h00A5, 16'h013C, 16'h0201,
                                           16'h0380, 16'h00FF, 16'h056E};

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       eng_acc = 1'b0, eng_no_autoclr = 1'b0, eng_count_zero = 1'b0;
    logic       ser_clk, ser_dout, ser_din, irq_tx_empty, irq_rx_full;

    int checks = 0, fails = 0;
    int mon_cnt = 0, irq_tx_hi = 0, irq_rx_hi = 0;
    logic [7:0] mon_sh = '0;
    logic       low_bit = 1'b1, sclk_prev = 1'b1;

    assign ser_din = ser_dout;

    always #2 clk = ~clk;

    sync_serial_port uut (.*);

    // capture data-out during each low half, commit it at each rising serial edge
    always @(negedge clk) begin
        if (ser_clk && !sclk_prev) begin
            mon_sh  = {low_bit, mon_sh[7:1]};
            mon_cnt = mon_cnt + 1;
        end
        if (!ser_clk) low_bit = ser_dout;
        sclk_prev = ser_clk;
        if (irq_tx_empty) irq_tx_hi = irq_tx_hi + 1;
        if (irq_rx_full)  irq_rx_hi = irq_rx_hi + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic eng_wr(input logic [7:0] d, input logic noauto, input logic cz);
        @(negedge clk);
        bus_addr = A_TXD; bus_wdata = d; bus_wr = 1'b1;
        eng_acc = 1'b1; eng_no_autoclr = noauto; eng_count_zero = cz;
        @(negedge clk);
        bus_wr = 1'b0; eng_acc = 1'b0; eng_no_autoclr = 1'b0; eng_count_zero = 1'b0;
    endtask

    task automatic eng_rd(input logic noauto, input logic cz, output logic [7:0] d);
        @(negedge clk);
        bus_addr = A_RXD; bus_rd = 1'b1;
        eng_acc = 1'b1; eng_no_autoclr = noauto; eng_count_zero = cz;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; eng_acc = 1'b0; eng_no_autoclr = 1'b0; eng_count_zero = 1'b0;
    endtask

    task automatic clear_with(input logic [7:0] pattern);
        logic [7:0] s;
        rd(A_STAT, s);
        wr(A_STAT, pattern);
    endtask

    task automatic send(input logic [7:0] d);
        wr(A_TXD, d);
        clear_with(8'hFE);
    endtask

    task automatic wait_bit(input int b, output bit got);
        logic [7:0] s;
        got = 1'b0;
        for (int i = 0; i < 400 && !got; i++) begin
            rd(A_STAT, s);
            if (s[b]) got = 1'b1;
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        bit got;
        int m0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, s); chk(s == 8'h00, "R1", "control", s, 0);
        rd(A_STAT, s); chk(s == 8'h01, "R1", "status", s, 1);
        chk(ser_clk && ser_dout, "R1", "pins", {ser_clk, ser_dout}, 3);
        chk(!irq_tx_empty && !irq_rx_full, "R1", "irqs",
            {irq_tx_empty, irq_rx_full}, 0);

        // R2 enable pair rule
        wr(A_CTRL, 8'h01); rd(A_CTRL, s); chk(s == 8'h01, "R2", "00->01", s, 1);
        wr(A_CTRL, 8'h03); rd(A_CTRL, s); chk(s == 8'h01, "R2", "01->11 ignored", s, 1);
        wr(A_CTRL, 8'h02); rd(A_CTRL, s); chk(s == 8'h01, "R2", "01->10 ignored", s, 1);
        wr(A_CTRL, 8'h00); rd(A_CTRL, s); chk(s == 8'h00, "R2", "->00", s, 0);
        wr(A_CTRL, 8'h03); rd(A_CTRL, s); chk(s == 8'h03, "R2", "00->11", s, 3);

        // vector table: duplex loopback transfers (R4, R5, R8)
        irq_tx_hi = 0; irq_rx_hi = 0;
        for (int v = 0; v < NVEC; v++) begin
            wr(A_RATE, VEC[v][15:8]);
            m0 = mon_cnt;
            send(VEC[v][7:0]);
            wait_bit(1, got);
            chk(got, "R5", "receive-full set", got, 1);
            rd(A_RXD, d); chk(d == VEC[v][7:0], "R5", "received byte", d, VEC[v][7:0]);
            chk(mon_sh == VEC[v][7:0], "R4", "LSB-first bits", mon_sh, VEC[v][7:0]);
            chk(mon_cnt - m0 == 8, "R4", "bits per frame", mon_cnt - m0, 8);
            rd(A_STAT, s); chk(s == 8'h03, "R4", "empty after load", s, 3);
            wr(A_STAT, 8'hFD);
        end
        repeat (3) @(negedge clk);
        chk(irq_tx_hi == NVEC, "R8", "tx irq cycles", irq_tx_hi, NVEC);
        chk(irq_rx_hi == NVEC, "R8", "rx irq cycles", irq_rx_hi, NVEC);

        // R7 half period with N=2
        wr(A_RATE, 8'h02);
        send(8'h5A);
        for (int i = 0; i < 20 && ser_clk; i++) @(negedge clk);
        m0 = 0;
        while (!ser_clk) begin m0++; @(negedge clk); end
        chk(m0 == 3, "R7", "low half", m0, 3);
        m0 = 0;
        while (ser_clk) begin m0++; @(negedge clk); end
        chk(m0 == 3, "R7", "high half", m0, 3);
        wait_bit(1, got);
        rd(A_RXD, d); chk(d == 8'h5A, "R7", "byte at N=2", d, 8'h5A);
        wr(A_STAT, 8'hFD);

        // R3 clearing protocol
        wr(A_RATE, 8'h00);
        send(8'h81);
        repeat (60) @(negedge clk);
        wr(A_STAT, 8'hF9);
        rd(A_STAT, s); chk(s == 8'h03, "R3", "write 0 without read", s, 3);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, s); chk(s == 8'h03, "R3", "write 1", s, 3);
        wr(A_STAT, 8'hF9);
        rd(A_STAT, s); chk(s == 8'h01, "R3", "read then write 0", s, 1);
        rd(A_RXD, d); chk(d == 8'h81, "R3", "data kept", d, 8'h81);

        // R11 back-to-back frames
        wr(A_RATE, 8'h03);
        m0 = mon_cnt;
        send(8'h4D);
        send(8'hB2);
        wait_bit(1, got);
        rd(A_RXD, d); chk(d == 8'h4D, "R11", "first byte", d, 8'h4D);
        wr(A_STAT, 8'hFD);
        wait_bit(1, got);
        rd(A_RXD, d); chk(d == 8'hB2, "R11", "second byte", d, 8'hB2);
        rd(A_STAT, s); chk(s == 8'h03, "R11", "no overrun", s, 3);
        chk(mon_cnt - m0 == 16, "R11", "bits", mon_cnt - m0, 16);
        wr(A_STAT, 8'hFD);

        // R9 engine auto-clear
        wr(A_RATE, 8'h00);
        eng_wr(8'h3C, 1'b1, 1'b0);
        repeat (60) @(negedge clk);
        rd(A_STAT, s); chk(s == 8'h01, "R9", "disabled auto-clear", s, 1);
        eng_wr(8'hC3, 1'b0, 1'b0);
        wait_bit(1, got);
        chk(got, "R9", "engine write started frame", got, 1);
        eng_rd(1'b0, 1'b1, d); chk(d == 8'hC3, "R9", "engine read data", d, 8'hC3);
        rd(A_STAT, s); chk(s == 8'h03, "R9", "count zero keeps flag", s, 3);
        eng_rd(1'b0, 1'b0, d);
        rd(A_STAT, s); chk(s == 8'h01, "R9", "engine read clears", s, 1);

        // R6 overrun and R10 disable
        wr(A_RATE, 8'h01);
        send(8'h11);
        wait_bit(1, got);
        send(8'h22);
        wait_bit(2, got);
        chk(got, "R6", "overrun set", got, 1);
        rd(A_RXD, d); chk(d == 8'h11, "R6", "rx data held", d, 8'h11);
        m0 = mon_cnt;
        send(8'h33);
        repeat (100) @(negedge clk);
        rd(A_STAT, s); chk(s == 8'h06, "R6", "frozen status", s, 6);
        chk(mon_cnt == m0, "R6", "no serial clock", mon_cnt - m0, 0);
        wr(A_CTRL, 8'h00);
        rd(A_STAT, s); chk(s == 8'h07, "R10", "disable sets empty keeps rx flags", s, 7);
        chk(ser_dout == 1'b1, "R10", "data-out idle", ser_dout, 1);
        clear_with(8'hF9);
        rd(A_STAT, s); chk(s == 8'h01, "R6", "flags cleared", s, 1);
        wr(A_CTRL, 8'h03);
        send(8'h33);
        wait_bit(1, got);
        rd(A_RXD, d); chk(d == 8'h33, "R6", "resumed", d, 8'h33);

        summary();
        $finish;
    end
endmodule